// File: doc/BRIEF.md
# AES-128 Key Expansion Step Unit

This unit performs one step of the AES-128 key schedule on 64-bit operands. The step is split into two operations that software issues one after the other. The first is the substitute operation. It takes the upper 32-bit word of a 64-bit key half and a 4-bit round number. It optionally rotates the word and passes each byte through the forward AES S-box. It then folds in the round constant and writes the resulting word into both halves of the 64-bit result. The second is the chain operation. It XOR-chains that word with the previous key half to produce the next half.

A full AES-128 round key is formed from the current low half `lo` and high half `hi` in three steps. First, `t = subst(hi, r)`. Then `lo' = chain(t, lo)`. Finally, `hi' = chain(lo', hi)`. The round number `r` runs from 0 to 9. Round number 10 is kept for the AES-256 schedule, where the word is substituted without rotation or constant. Round numbers above 10 are rejected with an illegal-operation flag. Storing round keys and stepping through the rounds are left to the caller.

The unit accepts one operation per cycle. The result is registered and appears one cycle after the request.

Top module: `aes_kstep_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, out_valid, out_illegal and out_res are all zero.
- R2: A request with in_valid high at a clock edge produces out_valid high for exactly the following cycle, with its result and flag. When in_valid is low at an edge, out_valid is low in the following cycle.
- R3: For the substitute operation (in_op = 0) with round number 0 to 9, the working word is in_a[63:32]. It is rotated right by 8 bits, so byte 0 moves to byte 3. Each byte is replaced by its forward AES S-box value in place, and the round constant is XORed into bits 7:0.
- R4: The round constant for round numbers 0 through 9 is, in order, 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0x1B and 0x36.
- R5: For the substitute operation with round number 10, the word is not rotated and no constant is applied. Only the S-box substitution acts.
- R6: A legal substitute result carries the same 32-bit word in out_res[63:32] and out_res[31:0].
- R7: A substitute operation with round number 11 to 15 raises out_illegal, and out_res is zero.
- R8: For the chain operation (in_op = 1), out_res[31:0] = in_a[63:32] ^ in_b[31:0] and out_res[63:32] = out_res[31:0] ^ in_b[63:32]. The round number has no effect on this operation.
- R9: Both operations are legal when enc_en or dec_en is high. When both are low, every request raises out_illegal, and out_res is zero.
- R10: The substitute operation ignores in_a[31:0] and in_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0 = substitute operation, 1 = chain operation |
| in_rnd | input | 4 | Round number for the substitute operation |
| in_a | input | 64 | First operand; only bits 63:32 are used |
| in_b | input | 64 | Second operand; used by the chain operation |
| enc_en | input | 1 | Encryption feature enable |
| dec_en | input | 1 | Decryption feature enable |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_res | output | 64 | Registered result |
| out_illegal | output | 1 | Request rejected; result forced to zero |

## Verification
Several kinds of patterns are used, and each separates different faults:

- **All-zero and single-one words** at round numbers 9 and 10 separate rotation from no rotation. They also expose a wrong constant byte position.
- **A full expansion of a published AES-128 key** through ten rounds, checked against the first and last round keys, ties the S-box, the constant sequence and the chain order together.
- **Random operands, rounds and enables**, compared with a bench model, cover the S-box over many byte values and the illegal-flag decision for every round number.
- **Paired requests** that differ only in in_a[31:0] or in_b show that the substitute path ignores them.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

    localparam int DATA_W   = 64;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int RND_W    = 4;
    localparam int LAST_RND = 10;

    typedef enum logic {
        OP_SUBST = 1'b0,
        OP_CHAIN = 1'b1
    } ks_op_e;

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [DATA_W-1:0] data;
    } ks_out_t;

    function automatic logic [7:0] gf_xtime(input logic [7:0] x);
        return {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Inverse by raising to the power 254; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] r;
        logic [7:0] base;
        logic [7:0] e;
        r    = 8'h01;
        base = x;
        e    = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int k);
        logic [15:0] d;
        d = {x, x} << k;
        return d[15:8];
    endfunction

    function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
        logic [7:0] v;
        v = gf_inv(x);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    // Constant doubles per round in GF(2^8); zero at and beyond the last round.
    function automatic logic [7:0] rcon_of(input logic [RND_W-1:0] rnd);
        logic [7:0] rc;
        rc = 8'h01;
        for (int i = 0; i < LAST_RND; i++) begin
            if (i < int'(rnd)) rc = gf_xtime(rc);
        end
        if (int'(rnd) >= LAST_RND) rc = 8'h00;
        return rc;
    endfunction

endpackage

// File: rtl/ks_subst_unit.sv
module ks_subst_unit
    import aes_ks_pkg::*;
#(
    parameter int W_W = aes_ks_pkg::WORD_W,
    parameter int R_W = aes_ks_pkg::RND_W
) (
    input  logic [W_W-1:0] word_i,
    input  logic [R_W-1:0] rnd_i,
    output logic [W_W-1:0] word_o
);
    localparam int NBYTES = W_W / BYTE_W;

    logic             no_rot;
    logic [W_W-1:0]   pre;
    logic [W_W-1:0]   subst;
    logic [BYTE_W-1:0] rc;

    assign no_rot = (int'(rnd_i) == LAST_RND);
    assign pre    = no_rot ? word_i : {word_i[BYTE_W-1:0], word_i[W_W-1:BYTE_W]};
    assign rc     = rcon_of(rnd_i);

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign subst[g*BYTE_W +: BYTE_W] = sbox_fwd(pre[g*BYTE_W +: BYTE_W]);
    end

    assign word_o = {subst[W_W-1:BYTE_W], subst[BYTE_W-1:0] ^ rc};
endmodule

// File: rtl/ks_chain_unit.sv
module ks_chain_unit #(
    parameter int HALF_W = aes_ks_pkg::WORD_W
) (
    input  logic [HALF_W-1:0]   a_hi_i,
    input  logic [2*HALF_W-1:0] b_i,
    output logic [2*HALF_W-1:0] res_o
);
    logic [HALF_W-1:0] lo_w;

    assign lo_w  = a_hi_i ^ b_i[HALF_W-1:0];
    assign res_o = {lo_w ^ b_i[2*HALF_W-1:HALF_W], lo_w};
endmodule

// File: rtl/ks_legal_check.sv
module ks_legal_check
    import aes_ks_pkg::*;
#(
    parameter int R_W = aes_ks_pkg::RND_W
) (
    input  ks_op_e         op_i,
    input  logic [R_W-1:0] rnd_i,
    input  logic           enc_en_i,
    input  logic           dec_en_i,
    output logic           illegal_o
);
    logic feat_off;
    logic rnd_bad;

    assign feat_off  = !(enc_en_i || dec_en_i);
    assign rnd_bad   = (op_i == OP_SUBST) && (int'(rnd_i) > LAST_RND);
    assign illegal_o = feat_off || rnd_bad;
endmodule

// File: rtl/aes_kstep_unit.sv
module aes_kstep_unit
    import aes_ks_pkg::*;
#(
    parameter int DW  = aes_ks_pkg::DATA_W,
    parameter int R_W = aes_ks_pkg::RND_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_op,
    input  logic [R_W-1:0] in_rnd,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic          enc_en,
    input  logic          dec_en,
    output logic          out_valid,
    output logic [DW-1:0] out_res,
    output logic          out_illegal
);
    localparam int HW = DW / 2;

    ks_op_e        op_c;
    logic [HW-1:0] sub_word;
    logic [DW-1:0] chain_res;
    logic [DW-1:0] res_c;
    logic          ill_c;
    ks_out_t       q;
    logic          unused_a_lo;

    assign op_c        = ks_op_e'(in_op);
    assign unused_a_lo = ^in_a[HW-1:0];

    ks_subst_unit #(.W_W(HW), .R_W(R_W)) i_subst (
        .word_i (in_a[DW-1:HW]),
        .rnd_i  (in_rnd),
        .word_o (sub_word)
    );

    ks_chain_unit #(.HALF_W(HW)) i_chain (
        .a_hi_i (in_a[DW-1:HW]),
        .b_i    (in_b),
        .res_o  (chain_res)
    );

    ks_legal_check #(.R_W(R_W)) i_legal (
        .op_i      (op_c),
        .rnd_i     (in_rnd),
        .enc_en_i  (enc_en),
        .dec_en_i  (dec_en),
        .illegal_o (ill_c)
    );

    always_comb begin
        res_c = '0;
        if (!ill_c) begin
            unique case (op_c)
                OP_SUBST: res_c = {sub_word, sub_word};
                OP_CHAIN: res_c = chain_res;
                default:  res_c = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_valid;
            if (in_valid) begin
                q.ill  <= ill_c;
                q.data <= res_c;
            end
        end
    end

    assign out_valid   = q.vld;
    assign out_illegal = q.ill;
    assign out_res     = q.data;
endmodule

// File: rtl/aes_kstep_chk.sv
module aes_kstep_chk #(
    parameter int DW  = 64,
    parameter int R_W = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_op,
    input logic [R_W-1:0] in_rnd,
    input logic [DW-1:0] in_a,
    input logic [DW-1:0] in_b,
    input logic          enc_en,
    input logic          dec_en,
    input logic          out_valid,
    input logic [DW-1:0] out_res,
    input logic          out_illegal
);
    localparam int HW = DW / 2;

    logic unused_chk_a_lo;
    assign unused_chk_a_lo = ^in_a[HW-1:0];

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_illegal && out_res == '0));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_dup_halves_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op) |=> (out_illegal || out_res[DW-1:HW] == out_res[HW-1:0]));

    p_bad_round_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && int'(in_rnd) > 10) |=> out_illegal);

    p_illegal_zero_r7: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_res == '0);

    p_chain_value_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op && (enc_en || dec_en)) |=>
            (out_res[HW-1:0] == $past(in_a[DW-1:HW] ^ in_b[HW-1:0]) &&
             out_res[DW-1:HW] == (out_res[HW-1:0] ^ $past(in_b[DW-1:HW]))));

    p_no_feature_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !enc_en && !dec_en) |=> out_illegal);
endmodule

bind aes_kstep_unit aes_kstep_chk #(.DW(DW), .R_W(R_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_rnd      (in_rnd),
    .in_a        (in_a),
    .in_b        (in_b),
    .enc_en      (enc_en),
    .dec_en      (dec_en),
    .out_valid   (out_valid),
    .out_res     (out_res),
    .out_illegal (out_illegal)
);

// File: tb/test_aes_kstep_unit.sv
module test_aes_kstep_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [3:0]  in_rnd = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        enc_en = 1'b1;
    logic        dec_en = 1'b1;
    logic        out_valid;
    logic [63:0] out_res;
    logic        out_illegal;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] got_res;
    logic        got_ill;
    logic        got_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_kstep_unit i_aes_kstep_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_rnd(in_rnd), .in_a(in_a), .in_b(in_b), .enc_en(enc_en),
        .dec_en(dec_en), .out_valid(out_valid), .out_res(out_res),
        .out_illegal(out_illegal)
    );

    function automatic logic [7:0] m_xt(input logic [7:0] x);
        return x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    endfunction

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= s;
            s = m_xt(s);
        end
        return p;
    endfunction

    // Inverse by search, affine by per-bit formula.
    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] inv = 0;
        logic [7:0] o;
        for (int y = 1; y < 256; y++)
            if (x != 0 && m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
        return o;
    endfunction

    function automatic logic [7:0] m_rc(input logic [3:0] r);
        case (r)
            4'd0: return 8'h01;  4'd1: return 8'h02;  4'd2: return 8'h04;
            4'd3: return 8'h08;  4'd4: return 8'h10;  4'd5: return 8'h20;
            4'd6: return 8'h40;  4'd7: return 8'h80;  4'd8: return 8'h1b;
            4'd9: return 8'h36;  default: return 8'h00;
        endcase
    endfunction

    function automatic logic [63:0] m_subst(input logic [63:0] a, input logic [3:0] r);
        logic [31:0] w = a[63:32];
        logic [31:0] s;
        if (r != 4'd10) w = {w[7:0], w[31:8]};
        for (int k = 0; k < 4; k++) s[k*8 +: 8] = m_sbox(w[k*8 +: 8]);
        s[7:0] ^= m_rc(r);
        return {s, s};
    endfunction

    function automatic logic [63:0] m_chain(input logic [63:0] a, input logic [63:0] b);
        logic [31:0] lo = a[63:32] ^ b[31:0];
        return {lo ^ b[63:32], lo};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic op, input logic [3:0] r, input logic [63:0] a,
                       input logic [63:0] b, input logic e, input logic d);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_rnd = r; in_a = a; in_b = b; enc_en = e; dec_en = d;
        @(negedge clk);
        got_res = out_res; got_ill = out_illegal; got_vld = out_valid;
        in_valid = 1'b0;
    endtask

    task automatic run_chk(input string req, input logic op, input logic [3:0] r,
                           input logic [63:0] a, input logic [63:0] b, input logic e, input logic d);
        logic        x_ill;
        logic [63:0] x_res;
        x_ill = !(e || d) || (!op && r > 4'd10);
        x_res = x_ill ? 64'h0 : (op ? m_chain(a, b) : m_subst(a, r));
        run(op, r, a, b, e, d);
        check(got_vld == 1'b1, {req, " valid"}, 64'(got_vld), 64'h1);
        check(got_ill == x_ill, {req, " illegal"}, 64'(got_ill), 64'(x_ill));
        check(got_res == x_res, {req, " result"}, got_res, x_res);
    endtask

    initial begin
        logic [63:0] lo;
        logic [63:0] hi;
        logic [63:0] t;
        logic [63:0] keep;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        // R1: held in reset
        check(out_valid == 0 && out_illegal == 0 && out_res == 0, "R1 in reset", out_res, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && out_illegal == 0 && out_res == 0, "R1 after reset", out_res, 64'h0);

        // R3 R4 R6: zero word at round 0
        run(1'b0, 4'd0, 64'h0, 64'h0, 1, 1);
        check(got_res == 64'h63636362_63636362, "R4 round0 constant", got_res, 64'h63636362_63636362);
        // R2: idle cycle after a pulse
        @(negedge clk);
        check(out_valid == 1'b0, "R2 idle after pulse", 64'(out_valid), 64'h0);
        // R5: no rotation/constant at round 10
        run(1'b0, 4'd10, 64'h00000001_00000000, 64'h0, 1, 1);
        check(got_res == 64'h6363637c_6363637c, "R5 no rotate", got_res, 64'h6363637c_6363637c);
        // R3 R4: rotation and 0x36 at round 9
        run(1'b0, 4'd9, 64'h00000001_00000000, 64'h0, 1, 1);
        check(got_res == 64'h7c636355_7c636355, "R3 rotate right", got_res, 64'h7c636355_7c636355);
        // R7: bad rounds
        for (int r = 11; r < 16; r++) begin
            run(1'b0, 4'(r), 64'hdeadbeef_01234567, 64'h55, 1, 0);
            check(got_ill == 1'b1 && got_res == 0, "R7 bad round", got_res, 64'h0);
        end
        // R10: low half of a and b ignored
        run(1'b0, 4'd3, 64'h1234abcd_00000000, 64'h0, 1, 1);
        keep = got_res;
        run(1'b0, 4'd3, 64'h1234abcd_ffff5a5a, 64'hffffffff_ffffffff, 1, 1);
        check(got_res == keep, "R10 ignores lo/b", got_res, keep);
        // R8: chain with round field set
        run_chk("R8 chain", 1'b1, 4'd15, 64'h0f0f0f0f_aaaaaaaa, 64'h12345678_ffff0000, 1, 1);
        // R9: enables
        run_chk("R9 none subst", 1'b0, 4'd2, 64'h11223344_0, 64'h0, 0, 0);
        run_chk("R9 none chain", 1'b1, 4'd0, 64'h11223344_0, 64'h9, 0, 0);
        run_chk("R9 dec only", 1'b0, 4'd2, 64'h11223344_0, 64'h0, 0, 1);
        run_chk("R9 enc only", 1'b1, 4'd0, 64'h11223344_0, 64'h9, 1, 0);

        // R3 R4 R8: published AES-128 key through ten rounds
        lo = 64'ha6d2ae28_16157e2b;
        hi = 64'h3c4fcf09_8815f7ab;
        for (int r = 0; r < 10; r++) begin
            run(1'b0, 4'(r), hi, 64'h0, 1, 0);
            t = got_res;
            check(t == m_subst(hi, 4'(r)), "R3 expand subst", t, m_subst(hi, 4'(r)));
            run(1'b1, 4'd0, t, lo, 1, 0);
            lo = got_res;
            run(1'b1, 4'd0, lo, hi, 1, 0);
            hi = got_res;
            if (r == 0) begin
                check(lo == 64'hb12c5488_17fefaa0, "R8 round1 lo", lo, 64'hb12c5488_17fefaa0);
                check(hi == 64'h05766c2a_3939a323, "R8 round1 hi", hi, 64'h05766c2a_3939a323);
            end
        end
        check(lo == 64'h8925eec9_a8f914d0, "R4 round10 lo", lo, 64'h8925eec9_a8f914d0);
        check(hi == 64'ha60c63b6_c80c3fe1, "R4 round10 hi", hi, 64'ha60c63b6_c80c3fe1);

        // R3 R7 R8 R9: random mix
        for (int n = 0; n < 300; n++) begin
            logic        op = 1'($urandom);
            logic [3:0]  r  = 4'($urandom % 16);
            logic [63:0] a  = {$urandom, $urandom};
            logic [63:0] b  = {$urandom, $urandom};
            logic        e  = ($urandom % 8) != 0;
            logic        d  = 1'($urandom);
            run_chk("R3/R8 random", op, r, a, b, e, d);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule